// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events and clock cycles for software that profiles a processor. It holds one free-running cycle counter and four programmable event counters, all 32 bits wide. Each event counter is given an event code. It then counts the clocks on which the matching one-bit event line is high. Code zero is different: that counter advances only when software writes to a software-increment register.

Software reaches every register over a simple synchronous bus with address, write enable, write data and a combinational read-data return. The event counters are not mapped one by one. Software first writes a counter index to a selector register, and the event-code and counter-value registers then act on the chosen counter. The cycle counter can be slowed so that it advances once every 64 clocks. Each counter that wraps sets a sticky overflow flag, and software clears the flag by writing a one to it.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every counter, the overflow flags, the enable mask, the selector and the control bits read as zero.
- R2: Control register (address 0x0): bit 0 is the global enable and bit 3 is the divide-by-64 select, and both read back as written. Bit 1 and bit 2 always read as zero.
- R3: Writing a one to control bit 1 clears all four event counters in the next cycle. Writing a one to control bit 2 clears the cycle counter and restarts its prescaler.
- R4: The cycle counter (address 0x7, readable and writable) advances by one on each clock while the global enable and enable bit 31 are both set. With control bit 3 set, it advances once every 64 clocks, counted from the last cycle-counter reset.
- R5: Enable-set register (address 0x1): writing a one to bit i (0 to 3) enables event counter i, and writing a one to bit 31 enables the cycle counter. Zero bits have no effect, and a read returns the current mask.
- R6: Selector register (address 0x4) stores an index from 0 to 3. A write of 4 or more is ignored, and the register keeps its previous value.
- R7: The event-code register (address 0x5) and the counter-value register (address 0x6) act on the selected counter. A counter with code k, where k is 1 to 11, adds one on each enabled clock on which eventIn bit k-1 is high.
- R8: A counter with code 12 or higher never counts. No counter advances while the global enable or its own enable bit is clear.
- R9: Writing to the software-increment register (address 0x3) with bit i set adds one to event counter i. This happens only if counter i has code 0 and is enabled. Counters with other codes are unaffected.
- R10: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag. The flags are bits 0 to 3 for the event counters and bit 31 for the cycle counter.
- R11: Overflow register (address 0x2): a read returns the flags. Writing a one to a bit clears that flag, and a zero bit leaves its flag unchanged.
- R12: Event-support register 0 (address 0x8) reads 0x00000FFF, and event-support register 1 (address 0x9) reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address |
| regWe | input | 1 | Write enable for the current cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| eventIn | input | 11 | Event lines; bit k-1 carries event code k |

## Verification
The embedded assertions check four properties on every cycle. An event-reset strobe leaves all event counters at zero. The cycle counter holds when it is not running and never rises by more than one per clock while divided. Enable bits and overflow flags never drop except through an explicit clear. A write of an out-of-range index leaves the selector unchanged. The bench scenarios check everything that needs exact counts. These are:
- which event line each code picks;
- the 64-clock cadence of the divided cycle counter;
- wrap-around and the flag it sets;
- the software-increment filter on code zero;
- the read-back values of the registers.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  parameter int NUM_CNT = 4;
  parameter int CNT_W = 32;
  parameter int CODE_W = 8;
  parameter int NUM_EVT = 12;
  parameter int ADDR_W = 4;
  parameter int PRE_W = 6;
  parameter int CYC_BIT = 31;
  localparam int SEL_W = $clog2(NUM_CNT);

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 4'h0,
    REG_ENSET  = 4'h1,
    REG_OVF    = 4'h2,
    REG_SWINC  = 4'h3,
    REG_SEL    = 4'h4,
    REG_EVTYPE = 4'h5,
    REG_EVCNT  = 4'h6,
    REG_CYCCNT = 4'h7,
    REG_EVID0  = 4'h8,
    REG_EVID1  = 4'h9
  } reg_addr_e;

  typedef struct packed {
    logic               evReset;
    logic               cycReset;
    logic               evWrite;
    logic               cycWrite;
    logic [NUM_CNT-1:0] swInc;
    logic [NUM_CNT:0]   ovfClr;
  } strobe_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic [CNT_W-1:0]              wdata,
  output logic [CNT_W-1:0]              rdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] evCount,
  input  logic [CNT_W-1:0]              cycCount,
  input  logic [NUM_CNT:0]              ovf,
  output strobe_t                       strb,
  output logic                          globalEn,
  output logic                          divEn,
  output logic [NUM_CNT:0]              cntEn,
  output logic [SEL_W-1:0]              sel,
  output logic [NUM_CNT-1:0][CODE_W-1:0] evType
);

  logic selOk;
  assign selOk = (wdata < CNT_W'(NUM_CNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      divEn    <= 1'b0;
      cntEn    <= '0;
      sel      <= '0;
      evType   <= '0;
    end else if (we) begin
      case (addr)
        REG_CTRL: begin
          globalEn <= wdata[0];
          divEn    <= wdata[3];
        end
        REG_ENSET:  cntEn <= cntEn | {wdata[CYC_BIT], wdata[NUM_CNT-1:0]};
        REG_SEL:    if (selOk) sel <= wdata[SEL_W-1:0];
        REG_EVTYPE: evType[sel] <= wdata[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.evReset  = we && (addr == REG_CTRL) && wdata[1];
    strb.cycReset = we && (addr == REG_CTRL) && wdata[2];
    strb.evWrite  = we && (addr == REG_EVCNT);
    strb.cycWrite = we && (addr == REG_CYCCNT);
    if (we && (addr == REG_SWINC)) strb.swInc = wdata[NUM_CNT-1:0];
    if (we && (addr == REG_OVF))   strb.ovfClr = {wdata[CYC_BIT], wdata[NUM_CNT-1:0]};
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTRL: begin
        rdata[0] = globalEn;
        rdata[3] = divEn;
      end
      REG_ENSET: begin
        rdata[NUM_CNT-1:0] = cntEn[NUM_CNT-1:0];
        rdata[CYC_BIT]     = cntEn[NUM_CNT];
      end
      REG_OVF: begin
        rdata[NUM_CNT-1:0] = ovf[NUM_CNT-1:0];
        rdata[CYC_BIT]     = ovf[NUM_CNT];
      end
      REG_SEL:    rdata[SEL_W-1:0] = sel;
      REG_EVTYPE: rdata[CODE_W-1:0] = evType[sel];
      REG_EVCNT:  rdata = evCount[sel];
      REG_CYCCNT: rdata = cycCount;
      REG_EVID0:  rdata[NUM_EVT-1:0] = '1;
      default:    rdata = '0;
    endcase
  end

  // R6
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (we && addr == REG_SEL && !selOk) |=> $stable(sel));

  // R5
  enable_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(cntEn) & ~cntEn) == '0));

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [CNT_W-1:0]               wdata,
  input  logic                           globalEn,
  input  logic                           divEn,
  input  logic [NUM_CNT:0]               cntEn,
  input  logic [SEL_W-1:0]               sel,
  input  logic [NUM_CNT-1:0][CODE_W-1:0] evType,
  input  logic [NUM_EVT-2:0]             eventIn,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  evCount,
  output logic [CNT_W-1:0]               cycCount,
  output logic [NUM_CNT:0]               ovf
);

  logic [NUM_CNT-1:0] hit, inc, wrEv, wrapEv;
  logic [PRE_W-1:0]   pre;
  logic               cycRun, tick, wrapCyc;

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      hit[i] = 1'b0;
      if (evType[i] == '0) hit[i] = strb.swInc[i];
      for (int k = 1; k < NUM_EVT; k++)
        if (evType[i] == CODE_W'(k)) hit[i] = eventIn[k-1];
      inc[i]    = globalEn && cntEn[i] && hit[i];
      wrEv[i]   = strb.evWrite && (sel == SEL_W'(i));
      wrapEv[i] = inc[i] && !strb.evReset && !wrEv[i] && (evCount[i] == '1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evCount <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (strb.evReset)  evCount[i] <= '0;
        else if (wrEv[i])  evCount[i] <= wdata;
        else if (inc[i])   evCount[i] <= evCount[i] + 1'b1;
      end
    end
  end

  assign cycRun  = globalEn && cntEn[NUM_CNT];
  assign tick    = cycRun && (!divEn || (pre == '1));
  assign wrapCyc = tick && !strb.cycReset && !strb.cycWrite && (cycCount == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre      <= '0;
      cycCount <= '0;
    end else begin
      if (strb.cycReset)  pre <= '0;
      else if (cycRun)    pre <= pre + 1'b1;
      if (strb.cycReset)      cycCount <= '0;
      else if (strb.cycWrite) cycCount <= wdata;
      else if (tick)          cycCount <= cycCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovf <= '0;
    else       ovf <= (ovf & ~strb.ovfClr) | {wrapCyc, wrapEv};
  end

  // R3
  event_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.evReset |=> (evCount == '0));

  // R4
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cycRun && !strb.cycReset && !strb.cycWrite) |=> $stable(cycCount));

  // R4
  cycle_div_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divEn && !strb.cycReset && !strb.cycWrite) |=> ((cycCount - $past(cycCount)) <= 1));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(ovf) & ~$past(strb.ovfClr)) & ~ovf) == '0));

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [CNT_W-1:0]    regWdata,
  output logic [CNT_W-1:0]    regRdata,
  input  logic [NUM_EVT-2:0]  eventIn
);

  strobe_t                        strb;
  logic                           globalEn, divEn;
  logic [NUM_CNT:0]               cntEn, ovf;
  logic [SEL_W-1:0]               sel;
  logic [NUM_CNT-1:0][CODE_W-1:0] evType;
  logic [NUM_CNT-1:0][CNT_W-1:0]  evCount;
  logic [CNT_W-1:0]               cycCount;

  pcu_ctrl ctrl (
    .clk(clk), .rstN(rstN), .addr(regAddr), .we(regWe), .wdata(regWdata),
    .rdata(regRdata), .evCount(evCount), .cycCount(cycCount), .ovf(ovf),
    .strb(strb), .globalEn(globalEn), .divEn(divEn), .cntEn(cntEn),
    .sel(sel), .evType(evType)
  );

  pcu_datapath dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(regWdata),
    .globalEn(globalEn), .divEn(divEn), .cntEn(cntEn), .sel(sel),
    .evType(evType), .eventIn(eventIn), .evCount(evCount),
    .cycCount(cycCount), .ovf(ovf)
  );

endmodule

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [10:0] eventIn = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] v;

  perf_counter_unit uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .eventIn(eventIn)
  );

  always #4 clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); check("R1 ctrl", v, 32'h0);
    rd(4'h1, v); check("R1 enset", v, 32'h0);
    rd(4'h2, v); check("R1 ovf", v, 32'h0);
    rd(4'h4, v); check("R1 sel", v, 32'h0);
    rd(4'h6, v); check("R1 evcnt", v, 32'h0);
    rd(4'h7, v); check("R1 cyc", v, 32'h0);
    // R12 event-support registers
    rd(4'h8, v); check("R12 evid0", v, 32'h0000_0FFF);
    rd(4'h9, v); check("R12 evid1", v, 32'h0);

    // R8 and R9: software increment needs both enables
    wr(4'h4, 0); wr(4'h5, 0);
    wr(4'h3, 32'h1); rd(4'h6, v); check("R8 swinc global off", v, 0);
    wr(4'h0, 32'h1);
    wr(4'h3, 32'h1); rd(4'h6, v); check("R8 swinc counter off", v, 0);
    wr(4'h1, 32'h1); rd(4'h1, v); check("R5 enset bit0", v, 32'h1);
    wr(4'h3, 32'h1); rd(4'h6, v); check("R9 swinc counts", v, 1);
    wr(4'h1, 32'h0); rd(4'h1, v); check("R5 zeros no effect", v, 32'h1);
    wr(4'h1, 32'hE); rd(4'h1, v); check("R5 enset mask", v, 32'hF);

    // R2 control read-back
    wr(4'h0, 32'hF); rd(4'h0, v); check("R2 ctrl readback", v, 32'h9);
    wr(4'h0, 32'h1); rd(4'h0, v); check("R2 ctrl enable only", v, 32'h1);

    // R9 filter on event code
    wr(4'h4, 1); wr(4'h5, 0); wr(4'h6, 0);
    wr(4'h4, 2); wr(4'h5, 3); wr(4'h6, 0);
    wr(4'h3, 32'h6);
    wr(4'h3, 32'h6);
    wr(4'h4, 1); rd(4'h6, v); check("R9 code0 counter", v, 2);
    wr(4'h4, 2); rd(4'h6, v); check("R9 other code unaffected", v, 0);

    // R6 selector range
    wr(4'h4, 2); wr(4'h4, 5); rd(4'h4, v); check("R6 sel ignore 5", v, 2);
    wr(4'h4, 32'h8000_0001); rd(4'h4, v); check("R6 sel ignore large", v, 2);
    wr(4'h4, 3); rd(4'h4, v); check("R6 sel 3", v, 3);

    // R8 global enable off blocks event counting
    wr(4'h4, 0); wr(4'h5, 1); wr(4'h6, 0);
    wr(4'h0, 32'h0);
    eventIn = '1; repeat (4) @(negedge clk); eventIn = '0;
    rd(4'h6, v); check("R8 global off", v, 0);
    wr(4'h0, 32'h1);

    // R7 and R8 sweep over every counter and code
    for (int idx = 0; idx < 4; idx++) begin
      for (int code = 0; code < 16; code++) begin
        wr(4'h4, idx); wr(4'h5, code); wr(4'h6, 0);
        rd(4'h5, v); check("R7 evtype readback", v, code);
        eventIn = '1; repeat (5) @(negedge clk); eventIn = '0;
        rd(4'h6, v);
        check((code >= 1 && code <= 11) ? "R7 all lines" : "R8 bad code", v,
              (code >= 1 && code <= 11) ? 5 : 0);
        if (code >= 1 && code <= 11) begin
          wr(4'h6, 0);
          eventIn = ~(11'h1 << (code - 1)); repeat (4) @(negedge clk);
          eventIn = 11'h1 << (code - 1);    repeat (3) @(negedge clk);
          eventIn = '0;
          rd(4'h6, v); check("R7 line select", v, 3);
        end
      end
    end

    // R10 and R11 event counter wrap
    wr(4'h4, 2); wr(4'h5, 2); wr(4'h6, 32'hFFFF_FFFE);
    eventIn = 11'h2; repeat (3) @(negedge clk); eventIn = '0;
    rd(4'h6, v); check("R10 event wrap value", v, 1);
    rd(4'h2, v); check("R10 event ovf flag", v, 32'h4);
    wr(4'h2, 32'h0); rd(4'h2, v); check("R11 zero keeps flag", v, 32'h4);
    wr(4'h2, 32'h4); rd(4'h2, v); check("R11 one clears flag", v, 32'h0);

    // R3 event reset
    rd(4'h6, v); check("R3 pre event reset", v, 1);
    wr(4'h0, 32'h3); rd(4'h6, v); check("R3 event reset", v, 0);

    // R4 cycle counter, full rate
    wr(4'h1, 32'h8000_0000); rd(4'h1, v); check("R5 enset bit31", v, 32'h8000_000F);
    wr(4'h0, 32'h5);
    rd(4'h7, v); check("R3 cycle reset", v, 0);
    repeat (20) @(negedge clk);
    rd(4'h7, v); check("R4 full rate", v, 20);

    // R4 divided by 64
    wr(4'h0, 32'hD);
    repeat (63) @(negedge clk); rd(4'h7, v); check("R4 div 63 clocks", v, 0);
    @(negedge clk);             rd(4'h7, v); check("R4 div 64 clocks", v, 1);
    repeat (128) @(negedge clk); rd(4'h7, v); check("R4 div 192 clocks", v, 3);
    wr(4'h0, 32'h5); rd(4'h7, v); check("R3 cycle reset again", v, 0);

    // R10 and R11 cycle wrap
    wr(4'h7, 32'hFFFF_FFFD);
    repeat (5) @(negedge clk);
    rd(4'h7, v); check("R10 cycle wrap value", v, 2);
    rd(4'h2, v); check("R10 cycle ovf flag", v & 32'h8000_000F, 32'h8000_0000);
    wr(4'h2, 32'hFFFF_FFFF); rd(4'h2, v); check("R11 clear all", v, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule